// File: doc/BRIEF.md
# CAN Interrupt Flag Register

This block keeps the interrupt request flags of a CAN controller and presents them as one readable word with a single interrupt request line. Two of the flags are sticky error warnings. One fires when the receive error count reaches the warning limit while the node is not bus-off. The other fires when the transmit error count reaches the limit, whatever the bus-off state. Each stays set until software writes a one to its bit.

The other two flags are live summaries of the mailbox pending vectors. One reports a pending remote request in any unmasked mailbox. The other reports a pending received data frame in any unmasked mailbox. These two follow their inputs in the same cycle, clear themselves when nothing unmasked remains, and ignore writes. The interrupt request is raised when any flag is set whose enable bit is also set.

Error counting, mailbox storage and the pending registers sit elsewhere and reach this block as plain inputs.

Top module: `can_irq_flags`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the flag word reads 0 and irq is 0 (with the mailbox pending inputs at 0).
- R2: Flag word bit 4 (receive warning) becomes 1 one clock after a rising edge that sees rx_err_cnt >= 96 with bus_off = 0. When bus_off = 1, a receive count alone never sets it.
- R3: Flag word bit 3 (transmit warning) becomes 1 one clock after a rising edge that sees tx_err_cnt >= 96, regardless of bus_off. A count of 95 does not set it.
- R4: A cycle with wr_en = 1 and wr_data bit 4 (or bit 3) = 1 clears that flag at the next edge, provided its set condition is false. A write with a 0 in that bit leaves the flag unchanged.
- R5: If a clearing write and a true set condition meet at the same edge, the flag stays 1. A cleared flag whose condition still holds returns to 1 at the next edge.
- R6: Flag word bit 2 equals, in the same cycle, the OR over all mailboxes of rmt_pend[i] AND NOT mbx_mask[i].
- R7: Flag word bit 1 equals, in the same cycle, the OR over all mailboxes of rx_pend[i] AND NOT mbx_mask[i].
- R8: Writes to bits 2 and 1, and to any other bit, have no effect. Bits 7..5 and bit 0 of the flag word always read 0.
- R9: irq equals the OR over the bits of (flag word AND irq_en).
- R10: A warning flag keeps its value 1 after its count falls below 96 until a clearing write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_err_cnt | input | CNT_W (8) | Receive error count |
| tx_err_cnt | input | CNT_W (8) | Transmit error count |
| bus_off | input | 1 | Node is in the bus-off state |
| rx_pend | input | NUM_MBX (16) | Per-mailbox data-frame pending |
| rmt_pend | input | NUM_MBX (16) | Per-mailbox remote-request pending |
| mbx_mask | input | NUM_MBX (16) | Per-mailbox interrupt mask, 1 = masked |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 8 | Write data, 1 in bit 4/3 clears that flag |
| irq_en | input | 8 | Per-flag interrupt enable, aligned to the flag word |
| flag_word | output | 8 | Current flag word |
| irq | output | 1 | Interrupt request |

## Verification
The error counts are drawn mostly from a narrow band around the limit (90..101), so that 95 against 96 is crossed often and with bus_off both high and low. This separates the qualified receive flag from the unqualified transmit flag. Clear writes land at random, sometimes on a cycle whose set condition holds, which tells a set-wins flag apart from a clear-wins one. The pending and mask vectors are sparse random patterns in which a single unmasked mailbox decides the summary, and the tests also cover a fully masked vector and a pattern where only the highest mailbox is pending. These reveal a dropped mask or a summary that is off by one mailbox. Directed steps check stickiness, writes of 0, and writes to the read-only bits.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int FLAG_W  = 8;
  localparam int BIT_RXW = 4;
  localparam int BIT_TXW = 3;
  localparam int BIT_RMT = 2;
  localparam int BIT_DAT = 1;

  typedef struct packed {
    logic rx_warn;
    logic tx_warn;
    logic remote;
    logic data;
  } flag_set_t;

  // threshold test on a zero-extended count
  function automatic logic warn_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt >= lim);
  endfunction

  // place the flag set at its bit positions, other bits zero
  function automatic logic [FLAG_W-1:0] pack_flags(input flag_set_t f);
    logic [FLAG_W-1:0] w;
    w          = '0;
    w[BIT_RXW] = f.rx_warn;
    w[BIT_TXW] = f.tx_warn;
    w[BIT_RMT] = f.remote;
    w[BIT_DAT] = f.data;
    return w;
  endfunction

  // a write clears a flag only when the strobe is up and the bit is one
  function automatic logic clear_req(input logic en, input logic [FLAG_W-1:0] d, input int pos);
    return en && d[pos];
  endfunction

endpackage

// File: rtl/cirq_warn_flag.sv
module cirq_warn_flag
  import can_irq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             qual,
  input  logic             clr_req,
  output logic             set_hit,
  output logic             flag
);

  logic flag_nx;

  assign set_hit = qual && warn_hit(32'(cnt), 32'(LIMIT));

  // set has priority over clear
  always_comb begin
    flag_nx = flag;
    if (clr_req) flag_nx = 1'b0;
    if (set_hit) flag_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nx;
  end

endmodule

// File: rtl/cirq_mbx_summary.sv
module cirq_mbx_summary #(
  parameter int NUM_MBX = 16
) (
  input  logic [NUM_MBX-1:0] pend,
  input  logic [NUM_MBX-1:0] mask,
  output logic               any_live
);

  logic [NUM_MBX-1:0] live;
  logic [NUM_MBX:0]   chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
    assign live[i]    = pend[i] & ~mask[i];
    assign chain[i+1] = chain[i] | live[i];
  end

  assign any_live = chain[NUM_MBX];

endmodule

// File: rtl/cirq_reg_port.sv
module cirq_reg_port
  import can_irq_pkg::*;
(
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  flag_set_t         flags,
  output logic              clr_rxw,
  output logic              clr_txw,
  output logic [FLAG_W-1:0] rd_data
);

  assign clr_rxw = clear_req(wr_en, wr_data, BIT_RXW);
  assign clr_txw = clear_req(wr_en, wr_data, BIT_TXW);
  assign rd_data = pack_flags(flags);

endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
#(
  parameter int NUM_MBX = 16,
  parameter int CNT_W   = 8,
  parameter int LIMIT   = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   rx_err_cnt,
  input  logic [CNT_W-1:0]   tx_err_cnt,
  input  logic               bus_off,
  input  logic [NUM_MBX-1:0] rx_pend,
  input  logic [NUM_MBX-1:0] rmt_pend,
  input  logic [NUM_MBX-1:0] mbx_mask,
  input  logic               wr_en,
  input  logic [FLAG_W-1:0]  wr_data,
  input  logic [FLAG_W-1:0]  irq_en,
  output logic [FLAG_W-1:0]  flag_word,
  output logic               irq
);

  // named internal events
  logic      rxw_set, txw_set;
  logic      rxw_clr, txw_clr;
  logic      rxw_q, txw_q;
  logic      rmt_any, dat_any;
  flag_set_t flags;

  cirq_warn_flag #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_rxw (
    .clk(clk), .rst_n(rst_n), .cnt(rx_err_cnt), .qual(~bus_off),
    .clr_req(rxw_clr), .set_hit(rxw_set), .flag(rxw_q)
  );

  cirq_warn_flag #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_txw (
    .clk(clk), .rst_n(rst_n), .cnt(tx_err_cnt), .qual(1'b1),
    .clr_req(txw_clr), .set_hit(txw_set), .flag(txw_q)
  );

  cirq_mbx_summary #(.NUM_MBX(NUM_MBX)) u_rmt (
    .pend(rmt_pend), .mask(mbx_mask), .any_live(rmt_any)
  );

  cirq_mbx_summary #(.NUM_MBX(NUM_MBX)) u_dat (
    .pend(rx_pend), .mask(mbx_mask), .any_live(dat_any)
  );

  assign flags.rx_warn = rxw_q;
  assign flags.tx_warn = txw_q;
  assign flags.remote  = rmt_any;
  assign flags.data    = dat_any;

  cirq_reg_port u_port (
    .wr_en(wr_en), .wr_data(wr_data), .flags(flags),
    .clr_rxw(rxw_clr), .clr_txw(txw_clr), .rd_data(flag_word)
  );

  assign irq = |(flag_word & irq_en);

endmodule

// File: rtl/can_irq_flags_chk.sv
module can_irq_flags_chk
  import can_irq_pkg::*;
#(
  parameter int NUM_MBX = 16,
  parameter int CNT_W   = 8,
  parameter int LIMIT   = 96
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   rx_err_cnt,
  input logic [CNT_W-1:0]   tx_err_cnt,
  input logic               bus_off,
  input logic [NUM_MBX-1:0] rx_pend,
  input logic [NUM_MBX-1:0] rmt_pend,
  input logic [NUM_MBX-1:0] mbx_mask,
  input logic               wr_en,
  input logic [FLAG_W-1:0]  wr_data,
  input logic [FLAG_W-1:0]  irq_en,
  input logic [FLAG_W-1:0]  flag_word,
  input logic               irq,
  input logic               rxw_set,
  input logic               txw_set
);

  logic rx_cond, tx_cond;
  assign rx_cond = !bus_off && (32'(rx_err_cnt) >= 32'(LIMIT));
  assign tx_cond = 32'(tx_err_cnt) >= 32'(LIMIT);

  // R2
  rxw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cond |=> flag_word[BIT_RXW]);

  // R2
  rxw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_word[BIT_RXW]) |-> $past(rx_cond));

  // R3
  txw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cond |=> flag_word[BIT_TXW]);

  // R4
  rxw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BIT_RXW] && !rxw_set) |=> !flag_word[BIT_RXW]);

  // R4
  txw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BIT_TXW] && !txw_set) |=> !flag_word[BIT_TXW]);

  // R10
  rxw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_word[BIT_RXW] && !(wr_en && wr_data[BIT_RXW])) |=> flag_word[BIT_RXW]);

  // R6
  rmt_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_word[BIT_RMT] |-> ((rmt_pend & ~mbx_mask) != '0));

  // R7
  dat_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_pend & ~mbx_mask) == '0) |-> !flag_word[BIT_DAT]);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flag_word & irq_en) != '0));

  // R8
  always_comb begin
    if (rst_n) begin
      unused_zero_chk: assert ((flag_word & 8'b1110_0001) == '0);
    end
  end

endmodule

bind can_irq_flags can_irq_flags_chk #(
  .NUM_MBX(NUM_MBX), .CNT_W(CNT_W), .LIMIT(LIMIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
  .bus_off(bus_off), .rx_pend(rx_pend), .rmt_pend(rmt_pend), .mbx_mask(mbx_mask),
  .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en), .flag_word(flag_word),
  .irq(irq), .rxw_set(rxw_set), .txw_set(txw_set)
);

// File: tb/can_irq_flags_tb_top.sv
`timescale 1ns/1ps
module can_irq_flags_tb_top;

  localparam int NM = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    rx_err_cnt = '0, tx_err_cnt = '0;
  logic          bus_off = 1'b0;
  logic [NM-1:0] rx_pend = '0, rmt_pend = '0, mbx_mask = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0, irq_en = '0;
  logic [7:0]    flag_word;
  logic          irq;

  int  n_tests = 0, n_fail = 0;
  bit  exp_rx = 1'b0, exp_tx = 1'b0;

  always #5 clk = ~clk;

  can_irq_flags #(.NUM_MBX(NM)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .bus_off(bus_off), .rx_pend(rx_pend), .rmt_pend(rmt_pend), .mbx_mask(mbx_mask),
    .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .flag_word(flag_word), .irq(irq)
  );

  function automatic bit m_any(input logic [NM-1:0] p, input logic [NM-1:0] m);
    bit r = 1'b0;
    for (int i = 0; i < NM; i++) if (p[i] && !m[i]) r = 1'b1;
    return r;
  endfunction

  function automatic bit m_warn(input logic [7:0] c, input bit blocked);
    return !blocked && (int'(c) > 95);
  endfunction

  function automatic logic [7:0] m_word();
    logic [7:0] w = 8'h00;
    w[4] = exp_rx;
    w[3] = exp_tx;
    w[2] = m_any(rmt_pend, mbx_mask);
    w[1] = m_any(rx_pend, mbx_mask);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare at mid-cycle, then advance one edge and update the model
  task automatic step();
    logic [7:0] w;
    #1;
    w = m_word();
    chk("R2 rx warn", 32'(flag_word[4]), 32'(w[4]));
    chk("R3 tx warn", 32'(flag_word[3]), 32'(w[3]));
    chk("R6 remote", 32'(flag_word[2]), 32'(w[2]));
    chk("R7 data", 32'(flag_word[1]), 32'(w[1]));
    chk("R8 unused", 32'(flag_word & 8'hE1), 32'h0);
    chk("R9 irq", 32'(irq), 32'(|(w & irq_en)));
    @(posedge clk);
    exp_rx = m_warn(rx_err_cnt, bus_off) || (exp_rx && !(wr_en && wr_data[4]));
    exp_tx = m_warn(tx_err_cnt, 1'b0)   || (exp_tx && !(wr_en && wr_data[3]));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic quiet();
    rx_err_cnt = 8'd0; tx_err_cnt = 8'd0; bus_off = 1'b0;
    rx_pend = '0; rmt_pend = '0; mbx_mask = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    irq_en = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset word", 32'(flag_word), 32'h0);
    chk("R1 reset irq", 32'(irq), 32'h0);
    rx_err_cnt = 8'd200; tx_err_cnt = 8'd200;
    @(negedge clk);
    chk("R1 held in reset", 32'(flag_word), 32'h0);
    quiet();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(flag_word), 32'h0);

    // R3 boundary 95 vs 96, R2 blocked by bus_off
    tx_err_cnt = 8'd95; step();
    chk("R3 at 95", 32'(flag_word[3]), 32'h0);
    rx_err_cnt = 8'd120; bus_off = 1'b1; tx_err_cnt = 8'd96; step();
    chk("R2 bus_off blocks", 32'(flag_word[4]), 32'h0);
    chk("R3 at 96 bus_off", 32'(flag_word[3]), 32'h1);
    bus_off = 1'b0; rx_err_cnt = 8'd96; step();
    chk("R2 at 96", 32'(flag_word[4]), 32'h1);
    // R10 sticky after count drops
    quiet(); step(); step();
    chk("R10 rx sticky", 32'(flag_word[4]), 32'h1);
    chk("R10 tx sticky", 32'(flag_word[3]), 32'h1);
    // R4 zero write leaves flags, R8 write to read-only bits
    rx_pend = 16'h0010; rmt_pend = 16'h0100;
    wr_en = 1'b1; wr_data = 8'b1110_0111; step();
    chk("R4 zero write", 32'(flag_word[4:3]), 32'h3);
    chk("R8 ro bits", 32'(flag_word[2:1]), 32'h3);
    // R4 clear rx only
    wr_en = 1'b1; wr_data = 8'h10; step();
    chk("R4 clear rx", 32'(flag_word[4:3]), 32'h1);
    // R5 set wins over clear on tx
    tx_err_cnt = 8'd150; wr_en = 1'b1; wr_data = 8'h08; step();
    chk("R5 set wins", 32'(flag_word[3]), 32'h1);
    // R6/R7 masking, highest mailbox
    quiet(); rmt_pend = 16'h8000; rx_pend = 16'h8000; mbx_mask = 16'h8000; step();
    mbx_mask = 16'h7FFF; step();
    mbx_mask = 16'hFFFF; rx_pend = 16'hFFFF; rmt_pend = 16'hFFFF; step();
    irq_en = 8'h02; rx_pend = 16'h0001; mbx_mask = 16'h0000; step();
    chk("R9 single enable", 32'(irq), 32'h1);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      rx_err_cnt = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(90, 101));
      tx_err_cnt = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(90, 101));
      bus_off    = ($urandom_range(0, 2) == 0);
      rx_pend    = NM'($urandom) & NM'($urandom) & NM'($urandom);
      rmt_pend   = NM'($urandom) & NM'($urandom) & NM'($urandom);
      mbx_mask   = NM'($urandom) | NM'($urandom);
      irq_en     = 8'($urandom);
      wr_en      = ($urandom_range(0, 3) == 0);
      wr_data    = 8'($urandom);
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule